// File: doc/BRIEF.md
# Dual-Bank IN Endpoint Controller

This block keeps track of the ping-pong buffers behind one device-side IN endpoint. Firmware fills the bank the block currently hands it, writes that bank's byte count, and then gives the bank away. The host side drains committed banks oldest-first. The block itself stores no payload. It tracks which bank firmware owns, how many banks wait for the host, and which bank and length the packet engine should send next.

Firmware sees two flags.
- The free flag signals that a fresh bank is ready. It drives the interrupt when the interrupt enable is high. Clearing it only acknowledges the event.
- The ownership flag shows that firmware holds the current bank. Releasing ownership commits the bank and moves to the next one. When that next bank is already empty, both flags come back on the same clock edge.

An abort path removes the newest committed bank on request, and an endpoint reset empties everything. The host side is a simplified token interface: an IN request, an ACK pulse and an abort-done pulse. Its outputs are a present/NAK indication plus the bank index and length.

Top module: `inep_bank_ctrl`

## Requirements
- R1: While `rst_n` is low, `fw_free`, `fw_own`, `fw_busy_cnt`, `fw_cur_bank`, `fw_kill_busy` and `host_tx_valid` are all 0. At the first clock edge after reset is released, `fw_free` and `fw_own` both become 1.
- R2: `fw_irq` is high exactly when `fw_free` and `fw_irq_en` are both high.
- R3: A `fw_free_clr` pulse clears `fw_free`. It leaves `fw_own`, `fw_busy_cnt` and `fw_cur_bank` unchanged.
- R4: A `fw_release` pulse while `fw_own` is 1 has these effects at the next edge:
  - `fw_busy_cnt` increments.
  - `fw_cur_bank` advances modulo the bank count.
  - If a bank is still free, `fw_own` and `fw_free` are 1 after that same edge.
  - If every bank is busy, `fw_own` is 0 and `fw_free` is not set.
- R5: A `fw_release` pulse while `fw_own` is 0 changes neither `fw_busy_cnt` nor `fw_cur_bank`.
- R6: Each bank index has its own byte-count register, written through `fw_len_we`/`fw_len_bank`/`fw_len_val`. One edge after a `host_in_req` with a nonzero busy count, `host_tx_valid` is 1, `host_tx_bank` is the oldest committed bank, and `host_tx_len` is that bank's byte count.
- R7: While a bank is presented:
  - `host_ack` frees it, decrements the busy count and drops `host_tx_valid` at the next edge.
  - `host_abort_done` drops `host_tx_valid` and keeps the bank busy.
- R8: A `host_in_req` while the busy count is 0 and nothing is presented makes `host_nak` high for exactly one cycle after the next edge.
- R9: A `fw_kill` pulse sets `fw_kill_busy` at the next edge. At a later edge with the kill allowed, the newest committed bank is removed: busy count minus one, `fw_cur_bank` steps back by one, and `fw_kill_busy` clears. If the busy count is 0, `fw_kill_busy` clears at the next edge with nothing removed.
- R10: A kill is held off while the only busy bank is being presented. If that presentation ends by ACK, the kill clears without removing anything. If it ends by abort-done, the bank is killed one edge later.
- R11: A `host_ack` and an accepted `fw_release` at the same edge leave `fw_busy_cnt` unchanged, and `fw_cur_bank` still advances.
- R12: A `fw_ep_reset` pulse clears the busy count, both pointers, the presentation, a pending kill and both flags at the next edge. The flags re-arm one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fw_irq_en | input | 1 | Interrupt enable for the free flag |
| fw_free_clr | input | 1 | Pulse: acknowledge (clear) the free flag |
| fw_release | input | 1 | Pulse: commit the current bank and give up ownership |
| fw_kill | input | 1 | Pulse: request removal of the newest committed bank |
| fw_ep_reset | input | 1 | Pulse: empty all banks and clear the endpoint state |
| fw_len_we | input | 1 | Byte-count write strobe |
| fw_len_bank | input | IDX_W (1) | Bank index for the byte-count write |
| fw_len_val | input | LEN_W (10) | Byte count to write |
| host_in_req | input | 1 | Pulse: host asks for an IN packet |
| host_ack | input | 1 | Pulse: host acknowledged the presented bank |
| host_abort_done | input | 1 | Pulse: presentation ended without acknowledge |
| fw_free | output | 1 | Free flag |
| fw_own | output | 1 | Ownership flag |
| fw_irq | output | 1 | Endpoint interrupt |
| fw_cur_bank | output | IDX_W (1) | Index of the bank firmware fills |
| fw_busy_cnt | output | CNT_W (2) | Number of committed, unsent banks |
| fw_kill_busy | output | 1 | Kill request pending |
| host_tx_valid | output | 1 | A bank is being presented to the host |
| host_tx_bank | output | IDX_W (1) | Presented bank index |
| host_tx_len | output | LEN_W (10) | Presented byte count |
| host_nak | output | 1 | One-cycle NAK for a request with no busy bank |

## Verification
The bank cycle is driven with several patterns:
- A single bank in flight at a time, swept over many rounds with distinct lengths, which checks pointer wrap and length pairing.
- Both banks filled before the host drains them, which checks oldest-first order and saturation.
- An ACK coinciding with a release, which separates a correct net-zero count from double counting.

Kills are tried in three situations, which tell the blocking rule apart from a naive immediate kill:
- With no busy bank.
- With two busy banks while the oldest is presented.
- Against a sole presented bank that ends by ACK or by abort-done.

// File: rtl/inep_pkg.sv
package inep_pkg;

    typedef enum logic {
        HOST_IDLE = 1'b0,
        HOST_SEND = 1'b1
    } host_st_e;

    typedef struct packed {
        logic free;
        logic own;
    } fw_flags_t;

endpackage

// File: rtl/inep_len_store.sv
module inep_len_store #(
    parameter int NB    = 2,
    parameter int LEN_W = 10,
    parameter int IDX_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [LEN_W-1:0] wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [LEN_W-1:0] rdata
);

    logic [LEN_W-1:0] len_d [NB];
    logic [LEN_W-1:0] len_q [NB];

    for (genvar b = 0; b < NB; b++) begin : g_bank
        always_comb begin
            len_d[b] = len_q[b];
            if (we && (widx == IDX_W'(b))) begin
                len_d[b] = wdata;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                len_q[b] <= '0;
            end else begin
                len_q[b] <= len_d[b];
            end
        end
    end

    assign rdata = len_q[ridx];

endmodule

// File: rtl/inep_queue.sv
module inep_queue #(
    parameter int NB    = 2,
    parameter int IDX_W = 1,
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ep_clr,
    input  logic             push,
    input  logic             pop,
    input  logic             kill_req,
    input  logic             tx_active,
    input  logic             tx_start,
    output logic [IDX_W-1:0] cur_idx,
    output logic [IDX_W-1:0] rd_idx,
    output logic [CNT_W-1:0] busy,
    output logic [CNT_W-1:0] busy_next,
    output logic             kill_pend,
    output logic             kill_fire
);

    typedef struct packed {
        logic [IDX_W-1:0] cur;
        logic [IDX_W-1:0] rd;
        logic [CNT_W-1:0] busy;
        logic             kill;
    } q_state_t;

    q_state_t s_d, s_q;
    logic [CNT_W:0] busy_sum;
    logic           kill_block;
    logic           kill_drop;

    function automatic logic [IDX_W-1:0] step_up(input logic [IDX_W-1:0] v);
        return (v == IDX_W'(NB - 1)) ? '0 : v + 1'b1;
    endfunction

    function automatic logic [IDX_W-1:0] step_down(input logic [IDX_W-1:0] v);
        return (v == '0) ? IDX_W'(NB - 1) : v - 1'b1;
    endfunction

    always_comb begin
        // a sole busy bank that is (or is about to be) on the wire is off limits
        kill_block = (s_q.busy == CNT_W'(1)) && (tx_active || tx_start);
        kill_fire  = s_q.kill && (s_q.busy != '0) && !kill_block && !push && !ep_clr;
        kill_drop  = s_q.kill && (s_q.busy == '0);

        s_d = s_q;
        if (push) begin
            s_d.cur = step_up(s_q.cur);
        end
        if (pop) begin
            s_d.rd = step_up(s_q.rd);
        end
        if (kill_fire) begin
            s_d.cur = step_down(s_q.cur);
        end

        busy_sum = {1'b0, s_q.busy}
                 + {{CNT_W{1'b0}}, push}
                 - {{CNT_W{1'b0}}, pop}
                 - {{CNT_W{1'b0}}, kill_fire};
        s_d.busy = busy_sum[CNT_W-1:0];
        s_d.kill = kill_req || (s_q.kill && !kill_fire && !kill_drop);

        if (ep_clr) begin
            s_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cur_idx   = s_q.cur;
    assign rd_idx    = s_q.rd;
    assign busy      = s_q.busy;
    assign busy_next = s_d.busy;
    assign kill_pend = s_q.kill;

    // R4: the count never passes the number of banks
    p_busy_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy <= CNT_W'(NB));

    // R4: a commit is only offered while a bank is free
    p_push_room_r4: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (busy < CNT_W'(NB)));

    // R4: an isolated commit adds exactly one busy bank
    p_release_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !ep_clr) |=> (busy == $past(busy) + CNT_W'(1)));

    // R9: a kill with nothing busy retires at the next edge
    p_kill_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (kill_pend && (busy == '0) && !kill_req) |=> !kill_pend);

endmodule

// File: rtl/inep_host_port.sv
module inep_host_port
    import inep_pkg::*;
#(
    parameter int IDX_W = 1,
    parameter int CNT_W = 2,
    parameter int LEN_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ep_clr,
    input  logic             in_req,
    input  logic             ack,
    input  logic             abort_done,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [CNT_W-1:0] busy,
    input  logic [LEN_W-1:0] rd_len,
    output logic             tx_start,
    output logic             pop,
    output logic             tx_active,
    output logic [IDX_W-1:0] tx_bank,
    output logic [LEN_W-1:0] tx_len,
    output logic             nak
);

    typedef struct packed {
        host_st_e         st;
        logic [IDX_W-1:0] bank;
        logic [LEN_W-1:0] len;
        logic             nak;
    } hp_state_t;

    hp_state_t h_d, h_q;

    always_comb begin
        tx_start = in_req && (h_q.st == HOST_IDLE) && (busy != '0);
        pop      = ack && (h_q.st == HOST_SEND);

        h_d     = h_q;
        h_d.nak = 1'b0;
        case (h_q.st)
            HOST_IDLE: begin
                if (tx_start) begin
                    h_d.st   = HOST_SEND;
                    h_d.bank = rd_idx;
                    h_d.len  = rd_len;
                end else if (in_req) begin
                    h_d.nak = 1'b1;
                end
            end
            HOST_SEND: begin
                if (ack || abort_done) begin
                    h_d.st = HOST_IDLE;
                end
            end
            default: h_d.st = HOST_IDLE;
        endcase

        if (ep_clr) begin
            h_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q <= '0;
        end else begin
            h_q <= h_d;
        end
    end

    assign tx_active = (h_q.st == HOST_SEND);
    assign tx_bank   = h_q.bank;
    assign tx_len    = h_q.len;
    assign nak       = h_q.nak;

    // R6: a bank is only presented while some bank is busy
    p_tx_has_bank_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_active |-> (busy != '0));

    // R8: an empty request is answered with a NAK
    p_nak_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_req && !tx_active && (busy == '0) && !ep_clr) |=> nak);

endmodule

// File: rtl/inep_bank_ctrl.sv
module inep_bank_ctrl
    import inep_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int LEN_W     = 10,
    localparam int IDX_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int CNT_W    = $clog2(NUM_BANKS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fw_irq_en,
    input  logic             fw_free_clr,
    input  logic             fw_release,
    input  logic             fw_kill,
    input  logic             fw_ep_reset,
    input  logic             fw_len_we,
    input  logic [IDX_W-1:0] fw_len_bank,
    input  logic [LEN_W-1:0] fw_len_val,
    input  logic             host_in_req,
    input  logic             host_ack,
    input  logic             host_abort_done,
    output logic             fw_free,
    output logic             fw_own,
    output logic             fw_irq,
    output logic [IDX_W-1:0] fw_cur_bank,
    output logic [CNT_W-1:0] fw_busy_cnt,
    output logic             fw_kill_busy,
    output logic             host_tx_valid,
    output logic [IDX_W-1:0] host_tx_bank,
    output logic [LEN_W-1:0] host_tx_len,
    output logic             host_nak
);

    fw_flags_t        f_d, f_q;
    logic             release_ok;
    logic             rearm;
    logic             tx_start;
    logic             pop;
    logic             kill_fire;
    logic [IDX_W-1:0] rd_idx;
    logic [CNT_W-1:0] busy_next;
    logic [LEN_W-1:0] rd_len;

    assign release_ok = fw_release && f_q.own && !fw_ep_reset;

    inep_len_store #(
        .NB    (NUM_BANKS),
        .LEN_W (LEN_W),
        .IDX_W (IDX_W)
    ) len_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (fw_len_we),
        .widx  (fw_len_bank),
        .wdata (fw_len_val),
        .ridx  (rd_idx),
        .rdata (rd_len)
    );

    inep_queue #(
        .NB    (NUM_BANKS),
        .IDX_W (IDX_W),
        .CNT_W (CNT_W)
    ) queue_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ep_clr    (fw_ep_reset),
        .push      (release_ok),
        .pop       (pop),
        .kill_req  (fw_kill),
        .tx_active (host_tx_valid),
        .tx_start  (tx_start),
        .cur_idx   (fw_cur_bank),
        .rd_idx    (rd_idx),
        .busy      (fw_busy_cnt),
        .busy_next (busy_next),
        .kill_pend (fw_kill_busy),
        .kill_fire (kill_fire)
    );

    inep_host_port #(
        .IDX_W (IDX_W),
        .CNT_W (CNT_W),
        .LEN_W (LEN_W)
    ) host_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ep_clr     (fw_ep_reset),
        .in_req     (host_in_req),
        .ack        (host_ack),
        .abort_done (host_abort_done),
        .rd_idx     (rd_idx),
        .busy       (fw_busy_cnt),
        .rd_len     (rd_len),
        .tx_start   (tx_start),
        .pop        (pop),
        .tx_active  (host_tx_valid),
        .tx_bank    (host_tx_bank),
        .tx_len     (host_tx_len),
        .nak        (host_nak)
    );

    always_comb begin
        f_d = f_q;
        if (fw_free_clr) begin
            f_d.free = 1'b0;
        end
        if (release_ok) begin
            f_d.own = 1'b0;
        end
        // hand firmware a bank whenever it holds none and one is empty
        rearm = (!f_q.own || release_ok) && (busy_next < CNT_W'(NUM_BANKS));
        if (rearm) begin
            f_d.own  = 1'b1;
            f_d.free = 1'b1;
        end
        if (fw_ep_reset) begin
            f_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign fw_free = f_q.free;
    assign fw_own  = f_q.own;
    assign fw_irq  = f_q.free && fw_irq_en;

    // R4: ownership is never held while every bank is busy
    p_own_room_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fw_own |-> (fw_busy_cnt < CNT_W'(NUM_BANKS)));

    // R3: acknowledging the free flag does not drop ownership
    p_ack_keeps_own_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fw_free_clr && fw_own && !fw_release && !fw_ep_reset) |=> fw_own);

    // R9: a removal always lowers the busy count
    p_kill_lowers_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (kill_fire && !pop) |=> (fw_busy_cnt == $past(fw_busy_cnt) - CNT_W'(1)));

endmodule

// File: tb/inep_bank_ctrl_tb_top.sv
module inep_bank_ctrl_tb_top;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fw_irq_en = 1'b0, fw_free_clr = 1'b0, fw_release = 1'b0;
    logic       fw_kill = 1'b0, fw_ep_reset = 1'b0, fw_len_we = 1'b0;
    logic [0:0] fw_len_bank = '0;
    logic [9:0] fw_len_val = '0;
    logic       host_in_req = 1'b0, host_ack = 1'b0, host_abort_done = 1'b0;
    logic       fw_free, fw_own, fw_irq, fw_kill_busy;
    logic [0:0] fw_cur_bank, host_tx_bank;
    logic [1:0] fw_busy_cnt;
    logic       host_tx_valid, host_nak;
    logic [9:0] host_tx_len;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_P / 2) clk = ~clk;

    inep_bank_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .fw_irq_en(fw_irq_en), .fw_free_clr(fw_free_clr),
        .fw_release(fw_release), .fw_kill(fw_kill), .fw_ep_reset(fw_ep_reset),
        .fw_len_we(fw_len_we), .fw_len_bank(fw_len_bank), .fw_len_val(fw_len_val),
        .host_in_req(host_in_req), .host_ack(host_ack), .host_abort_done(host_abort_done),
        .fw_free(fw_free), .fw_own(fw_own), .fw_irq(fw_irq), .fw_cur_bank(fw_cur_bank),
        .fw_busy_cnt(fw_busy_cnt), .fw_kill_busy(fw_kill_busy),
        .host_tx_valid(host_tx_valid), .host_tx_bank(host_tx_bank),
        .host_tx_len(host_tx_len), .host_nak(host_nak)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic write_len(input int bank, input int val);
        fw_len_we = 1'b1; fw_len_bank = 1'(bank); fw_len_val = 10'(val);
        tick();
        fw_len_we = 1'b0;
    endtask

    task automatic do_release();
        fw_release = 1'b1; tick(); fw_release = 1'b0;
    endtask

    task automatic do_req();
        host_in_req = 1'b1; tick(); host_in_req = 1'b0;
    endtask

    task automatic do_ack();
        host_ack = 1'b1; tick(); host_ack = 1'b0;
    endtask

    task automatic do_abort();
        host_abort_done = 1'b1; tick(); host_abort_done = 1'b0;
    endtask

    task automatic do_kill();
        fw_kill = 1'b1; tick(); fw_kill = 1'b0;
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: act=%0d exp=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int exp_cur;
        #(CLK_P * 3 + 2);
        chk("R1 free in reset", int'(fw_free), 0);
        chk("R1 own in reset", int'(fw_own), 0);
        chk("R1 busy in reset", int'(fw_busy_cnt), 0);
        chk("R1 cur in reset", int'(fw_cur_bank), 0);
        chk("R1 kill in reset", int'(fw_kill_busy), 0);
        chk("R1 tx in reset", int'(host_tx_valid), 0);
        rst_n = 1'b1;
        tick();
        chk("R1 free armed", int'(fw_free), 1);
        chk("R1 own armed", int'(fw_own), 1);

        for (int en = 0; en < 2; en++) begin
            fw_irq_en = 1'(en); #1;
            chk("R2 irq with free", int'(fw_irq), en);
        end
        fw_free_clr = 1'b1; tick(); fw_free_clr = 1'b0;
        chk("R3 free cleared", int'(fw_free), 0);
        chk("R3 own kept", int'(fw_own), 1);
        chk("R3 busy kept", int'(fw_busy_cnt), 0);
        chk("R3 cur kept", int'(fw_cur_bank), 0);
        for (int en = 0; en < 2; en++) begin
            fw_irq_en = 1'(en); #1;
            chk("R2 irq without free", int'(fw_irq), 0);
        end

        write_len(0, 'h11);
        write_len(1, 'h22);
        do_release();
        chk("R4 busy after commit", int'(fw_busy_cnt), 1);
        chk("R4 cur advanced", int'(fw_cur_bank), 1);
        chk("R4 own rearmed", int'(fw_own), 1);
        chk("R4 free rearmed", int'(fw_free), 1);
        chk("R2 irq raised", int'(fw_irq), 1);
        fw_free_clr = 1'b1; tick(); fw_free_clr = 1'b0;
        do_release();
        chk("R4 busy full", int'(fw_busy_cnt), 2);
        chk("R4 cur wrapped", int'(fw_cur_bank), 0);
        chk("R4 own withheld", int'(fw_own), 0);
        chk("R4 free withheld", int'(fw_free), 0);

        do_release();
        chk("R5 busy unchanged", int'(fw_busy_cnt), 2);
        chk("R5 cur unchanged", int'(fw_cur_bank), 0);

        do_req();
        chk("R6 tx valid", int'(host_tx_valid), 1);
        chk("R6 tx bank oldest", int'(host_tx_bank), 0);
        chk("R6 tx len", int'(host_tx_len), 'h11);
        do_abort();
        chk("R7 abort drops tx", int'(host_tx_valid), 0);
        chk("R7 abort keeps busy", int'(fw_busy_cnt), 2);
        do_req();
        chk("R7 same bank again", int'(host_tx_bank), 0);
        do_ack();
        chk("R7 ack frees", int'(fw_busy_cnt), 1);
        chk("R7 ack drops tx", int'(host_tx_valid), 0);
        chk("R4 own after ack", int'(fw_own), 1);
        chk("R4 free after ack", int'(fw_free), 1);

        write_len(0, 'h33);
        do_req();
        chk("R6 second bank", int'(host_tx_bank), 1);
        chk("R6 second len", int'(host_tx_len), 'h22);
        host_ack = 1'b1; fw_release = 1'b1; tick();
        host_ack = 1'b0; fw_release = 1'b0;
        chk("R11 net zero busy", int'(fw_busy_cnt), 1);
        chk("R11 cur advanced", int'(fw_cur_bank), 1);

        do_req();
        chk("R6 rewritten len", int'(host_tx_len), 'h33);
        do_kill();
        chk("R9 kill pending", int'(fw_kill_busy), 1);
        tick(); tick();
        chk("R10 kill held", int'(fw_kill_busy), 1);
        chk("R10 bank kept", int'(fw_busy_cnt), 1);
        do_abort();
        chk("R10 still held at abort", int'(fw_kill_busy), 1);
        tick();
        chk("R10 kill done", int'(fw_kill_busy), 0);
        chk("R9 bank removed", int'(fw_busy_cnt), 0);
        chk("R9 cur stepped back", int'(fw_cur_bank), 0);

        do_kill();
        chk("R9 empty kill set", int'(fw_kill_busy), 1);
        tick();
        chk("R9 empty kill clears", int'(fw_kill_busy), 0);
        chk("R9 empty busy", int'(fw_busy_cnt), 0);

        do_req();
        chk("R8 nak", int'(host_nak), 1);
        chk("R8 no tx", int'(host_tx_valid), 0);
        tick();
        chk("R8 nak one cycle", int'(host_nak), 0);

        do_release();
        do_req();
        do_kill();
        do_ack();
        chk("R10 kill held through ack", int'(fw_kill_busy), 1);
        chk("R10 acked", int'(fw_busy_cnt), 0);
        tick();
        chk("R10 kill retired", int'(fw_kill_busy), 0);
        chk("R10 nothing killed", int'(fw_cur_bank), 1);

        do_release();
        do_release();
        chk("R4 two busy", int'(fw_busy_cnt), 2);
        do_req();
        chk("R6 oldest is bank1", int'(host_tx_bank), 1);
        do_kill();
        tick();
        chk("R9 newest killed", int'(fw_busy_cnt), 1);
        chk("R9 cur back", int'(fw_cur_bank), 0);
        chk("R9 own back", int'(fw_own), 1);
        chk("R9 tx untouched", int'(host_tx_valid), 1);
        chk("R9 tx bank kept", int'(host_tx_bank), 1);
        do_ack();
        chk("R7 drained", int'(fw_busy_cnt), 0);

        do_release();
        do_req();
        fw_kill = 1'b1; fw_ep_reset = 1'b1; tick();
        fw_kill = 1'b0; fw_ep_reset = 1'b0;
        chk("R12 busy cleared", int'(fw_busy_cnt), 0);
        chk("R12 cur cleared", int'(fw_cur_bank), 0);
        chk("R12 tx cleared", int'(host_tx_valid), 0);
        chk("R12 kill cleared", int'(fw_kill_busy), 0);
        chk("R12 own cleared", int'(fw_own), 0);
        tick();
        chk("R12 own rearmed", int'(fw_own), 1);
        chk("R12 free rearmed", int'(fw_free), 1);

        exp_cur = 0;
        for (int r = 0; r < 6; r++) begin
            write_len(exp_cur, r * 37 + 5);
            do_release();
            do_req();
            chk("R6 sweep bank", int'(host_tx_bank), exp_cur);
            chk("R6 sweep len", int'(host_tx_len), r * 37 + 5);
            do_ack();
            chk("R7 sweep drained", int'(fw_busy_cnt), 0);
            exp_cur ^= 1;
            chk("R4 sweep cur", int'(fw_cur_bank), exp_cur);
        end

        for (int r = 0; r < 3; r++) begin
            write_len(exp_cur, 100 + r);
            write_len(exp_cur ^ 1, 200 + r);
            do_release();
            do_release();
            chk("R4 pair full", int'(fw_busy_cnt), 2);
            for (int k = 0; k < 2; k++) begin
                do_req();
                chk("R6 pair order", int'(host_tx_len), (k == 0) ? 100 + r : 200 + r);
                do_ack();
            end
            chk("R7 pair drained", int'(fw_busy_cnt), 0);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule